// File: doc/BRIEF.md
# Engine Configuration Table with Break

This block is the read-only configuration space that sits at the base of a slave's 1 KiB address window. Host software reads it word by word to learn what the slave holds. The first word is a fixed chip identifier. The next two words describe two built-in engines. After those comes one descriptor word for each attached engine, in the order the engines were attached. A zero word marks the end of the table. Every word past the end reads as a fixed error pattern.

The block also watches writes. If the host writes the break word to either of two locations, the block raises a one-cycle reset pulse to every device on the local bus. All other writes have no effect, and the table itself never changes.

Accesses are 32-bit and word-aligned. Every access completes in the cycle it is issued. The number of attached engines is a parameter. Their descriptor words arrive as a constant packed vector.

Top module: `eng_cfg_table`

## Requirements
- R1: A read at byte offset 0x000 returns 0xC0022D15.
- R2: Descriptor words use this layout: bit 31 is the next-entry flag, bits 23:16 are slots, bits 15:12 are version, bits 11:4 are type and bits 3:0 are the check code. A read at 0x004 returns the peek-engine descriptor 0x8001102C (flag 1, slots 1, version 1, type 0x02, code 0xC).
- R3: A read at 0x008 returns the bus-engine descriptor 0x8001503A (flag 1, slots 1, version 5, type 0x03, code 0xA).
- R4: A read at 0x00C + 4*k, for k below NUM_ENG, returns attached descriptor k. Descriptor k is taken from bits 32*k+31 down to 32*k of `eng_desc`.
- R5: A read at 0x00C + 4*NUM_ENG returns 0x00000000, which ends the table.
- R6: A read at any aligned offset above the end word, up to 0x3FC, returns 0xC0DE0000.
- R7: A write of 0xC0DE0000 to byte offset 0x000 or 0x010 drives `bus_rst` high for exactly the one cycle after the write cycle.
- R8: Any other write, whether a different value or a different offset, leaves `bus_rst` low and changes no readable word.
- R9: `ready` is high in every cycle where `rd_en` or `wr_en` is high, and low otherwise.
- R10: `rd_data` is zero in any cycle where `rd_en` is low.
- R11: Reset drives `bus_rst` low and suppresses a pulse that is pending. Reset leaves the readable table unchanged.
- R12: An access whose address bits 1:0 are not zero is treated as follows: a read returns 0xC0DE0000, and a write, even of the break word, produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte offset within the window |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the cycle of `rd_en` |
| ready | output | 1 | Access complete, same cycle |
| eng_desc | input | 32*max(NUM_ENG,1) | Attached engine descriptor words, packed, element 0 lowest |
| bus_rst | output | 1 | One-cycle local-bus reset pulse |

## Verification
The assertions take three things for granted about the inputs:
- `rd_en` and `wr_en` are never high in the same cycle.
- `eng_desc` is held constant.
- `addr` stays within the 1 KiB window.

The stimulus keeps to these conditions. Each random step issues exactly one strobe, draws offsets only from the window, and drives a fixed descriptor vector. Break words are aimed deliberately both at the two trigger offsets and away from them, so that firing and non-firing writes both occur.

// File: rtl/ect_pkg.sv
package ect_pkg;

    localparam int WORD_W      = 32;
    localparam int FIXED_WORDS = 3;

    localparam logic [WORD_W-1:0] CHIP_ID_WORD = 32'hC002_2D15;
    localparam logic [WORD_W-1:0] BREAK_WORD   = 32'hC0DE_0000;
    localparam logic [WORD_W-1:0] ERR_WORD     = 32'hC0DE_0000;
    localparam logic [WORD_W-1:0] END_WORD     = 32'h0000_0000;

    localparam logic [7:0] KIND_PEEK   = 8'h02;
    localparam logic [7:0] KIND_BUSENG = 8'h03;

    // Word offsets that accept the break word
    localparam int BREAK_TAP_A = 0;
    localparam int BREAK_TAP_B = 4;

    typedef enum logic [2:0] {
        RG_ID,
        RG_PEEK,
        RG_BUSENG,
        RG_ENGINE,
        RG_END,
        RG_ERR
    } region_e;

    typedef struct packed {
        logic       more;
        logic [6:0] rsvd;
        logic [7:0] slots;
        logic [3:0] ver;
        logic [7:0] kind;
        logic [3:0] crc;
    } desc_t;

    function automatic desc_t make_desc(input logic       more,
                                        input logic [7:0] slots,
                                        input logic [3:0] ver,
                                        input logic [7:0] kind,
                                        input logic [3:0] crc);
        desc_t d;
        d.more  = more;
        d.rsvd  = '0;
        d.slots = slots;
        d.ver   = ver;
        d.kind  = kind;
        d.crc   = crc;
        return d;
    endfunction

    localparam desc_t PEEK_DESC   = make_desc(1'b1, 8'h01, 4'h1, KIND_PEEK,   4'hC);
    localparam desc_t BUSENG_DESC = make_desc(1'b1, 8'h01, 4'h5, KIND_BUSENG, 4'hA);

endpackage

// File: rtl/ect_addr_decode.sv
module ect_addr_decode
    import ect_pkg::*;
#(
    parameter int NUM_ENG = 4,
    parameter int WIDX_W  = 8,
    parameter int IDX_W   = 2
) (
    input  logic [WIDX_W-1:0] widx,
    input  logic              aligned,
    output region_e           region,
    output logic [IDX_W-1:0]  eng_idx
);

    localparam int END_IDX = FIXED_WORDS + NUM_ENG;

    always_comb begin
        region  = RG_ERR;
        eng_idx = '0;
        if (aligned) begin
            if (int'(widx) == 0) begin
                region = RG_ID;
            end else if (int'(widx) == 1) begin
                region = RG_PEEK;
            end else if (int'(widx) == 2) begin
                region = RG_BUSENG;
            end else if (int'(widx) < END_IDX) begin
                region  = RG_ENGINE;
                eng_idx = IDX_W'(int'(widx) - FIXED_WORDS);
            end else if (int'(widx) == END_IDX) begin
                region = RG_END;
            end
        end
    end

endmodule

// File: rtl/ect_read_mux.sv
module ect_read_mux
    import ect_pkg::*;
#(
    parameter int NUM_ENG   = 4,
    parameter int ENG_SLOTS = 4,
    parameter int IDX_W     = 2
) (
    input  logic                      rd_en,
    input  region_e                   region,
    input  logic [IDX_W-1:0]          eng_idx,
    input  logic [ENG_SLOTS*WORD_W-1:0] eng_desc,
    output logic [WORD_W-1:0]         rd_data
);

    logic [WORD_W-1:0] desc_arr [ENG_SLOTS];
    logic [WORD_W-1:0] eng_word;
    logic [WORD_W-1:0] sel_word;

    for (genvar g = 0; g < ENG_SLOTS; g++) begin : g_unpack
        assign desc_arr[g] = eng_desc[g*WORD_W +: WORD_W];
    end

    if (NUM_ENG == 0) begin : g_no_eng
        logic unused_ok;
        assign unused_ok = ^{eng_idx, desc_arr[0]};
        assign eng_word  = '0;
    end else begin : g_eng
        always_comb begin
            eng_word = '0;
            for (int i = 0; i < ENG_SLOTS; i++) begin
                if (int'(eng_idx) == i) eng_word = desc_arr[i];
            end
        end
    end

    always_comb begin
        unique case (region)
            RG_ID:     sel_word = CHIP_ID_WORD;
            RG_PEEK:   sel_word = PEEK_DESC;
            RG_BUSENG: sel_word = BUSENG_DESC;
            RG_ENGINE: sel_word = eng_word;
            RG_END:    sel_word = END_WORD;
            default:   sel_word = ERR_WORD;
        endcase
        rd_data = rd_en ? sel_word : '0;
    end

endmodule

// File: rtl/ect_break_detect.sv
module ect_break_detect
    import ect_pkg::*;
#(
    parameter int WIDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              aligned,
    input  logic [WIDX_W-1:0] widx,
    input  logic [WORD_W-1:0] wr_data,
    output logic              bus_rst
);

    logic tap_hit;
    logic fire;

    assign tap_hit = (int'(widx) == BREAK_TAP_A) || (int'(widx) == BREAK_TAP_B);
    assign fire    = wr_en && aligned && tap_hit && (wr_data == BREAK_WORD);

    always_ff @(posedge clk) begin
        if (rst) bus_rst <= 1'b0;
        else     bus_rst <= fire;
    end

endmodule

// File: rtl/eng_cfg_table.sv
module eng_cfg_table
    import ect_pkg::*;
#(
    parameter int NUM_ENG = 4,
    parameter int ADDR_W  = 10,
    localparam int ENG_SLOTS = (NUM_ENG > 0) ? NUM_ENG : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        rd_en,
    input  logic                        wr_en,
    input  logic [31:0]                 wr_data,
    output logic [31:0]                 rd_data,
    output logic                        ready,
    input  logic [ENG_SLOTS*32-1:0]     eng_desc,
    output logic                        bus_rst
);

    localparam int WIDX_W = ADDR_W - 2;
    localparam int IDX_W  = (ENG_SLOTS > 1) ? $clog2(ENG_SLOTS) : 1;

    logic [WIDX_W-1:0] widx;
    logic              aligned;
    region_e           region;
    logic [IDX_W-1:0]  eng_idx;

    assign widx    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign ready   = rd_en | wr_en;

    ect_addr_decode #(
        .NUM_ENG (NUM_ENG),
        .WIDX_W  (WIDX_W),
        .IDX_W   (IDX_W)
    ) u_decode (
        .widx    (widx),
        .aligned (aligned),
        .region  (region),
        .eng_idx (eng_idx)
    );

    ect_read_mux #(
        .NUM_ENG   (NUM_ENG),
        .ENG_SLOTS (ENG_SLOTS),
        .IDX_W     (IDX_W)
    ) u_rmux (
        .rd_en    (rd_en),
        .region   (region),
        .eng_idx  (eng_idx),
        .eng_desc (eng_desc),
        .rd_data  (rd_data)
    );

    ect_break_detect #(
        .WIDX_W (WIDX_W)
    ) u_brk (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .aligned (aligned),
        .widx    (widx),
        .wr_data (wr_data),
        .bus_rst (bus_rst)
    );

endmodule

// File: rtl/ect_chk.sv
module ect_chk
    import ect_pkg::*;
#(
    parameter int NUM_ENG = 4,
    parameter int ADDR_W  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [31:0]       wr_data,
    input logic [31:0]       rd_data,
    input logic              ready,
    input logic              bus_rst
);

    localparam int END_IDX = FIXED_WORDS + NUM_ENG;

    logic ok_align;
    int   wi;
    logic brk_wr;

    assign ok_align = (addr[1:0] == 2'b00);
    assign wi       = int'(addr[ADDR_W-1:2]);
    assign brk_wr   = wr_en && ok_align && (wi == BREAK_TAP_A || wi == BREAK_TAP_B)
                      && (wr_data == BREAK_WORD);

    AST_ID_WORD: assert property (@(posedge clk) disable iff (rst)
        (rd_en && ok_align && wi == 0) |-> rd_data == 32'hC002_2D15);  // R1
    AST_END_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && ok_align && wi == END_IDX) |-> rd_data == 32'h0);  // R5
    AST_TAIL_ERR: assert property (@(posedge clk) disable iff (rst)
        (rd_en && ok_align && wi > END_IDX) |-> rd_data == 32'hC0DE_0000);  // R6
    AST_BREAK_FIRES: assert property (@(posedge clk) disable iff (rst)
        brk_wr |=> bus_rst);  // R7
    AST_NO_STRAY_RST: assert property (@(posedge clk) disable iff (rst)
        !brk_wr |=> !bus_rst);  // R8
    AST_READY_SAME: assert property (@(posedge clk) disable iff (rst)
        ready == (rd_en || wr_en));  // R9
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rd_data == 32'h0);  // R10
    AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !ok_align) |-> rd_data == 32'hC0DE_0000);  // R12

endmodule

bind eng_cfg_table ect_chk #(
    .NUM_ENG (NUM_ENG),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .ready   (ready),
    .bus_rst (bus_rst)
);

// File: tb/tb_eng_cfg_table.sv
`timescale 1ns/1ps
module tb_eng_cfg_table;

    localparam int NENG = 4;
    localparam int AW   = 10;
    localparam logic [31:0] D0 = 32'h8001_2045;
    localparam logic [31:0] D1 = 32'h8001_4107;
    localparam logic [31:0] D2 = 32'h8002_1C58;
    localparam logic [31:0] D3 = 32'h0001_0E63;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic          ready;
    logic [NENG*32-1:0] eng_desc = {D3, D2, D1, D0};
    logic          bus_rst;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    eng_cfg_table #(.NUM_ENG(NENG), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .ready(ready),
        .eng_desc(eng_desc), .bus_rst(bus_rst)
    );

    function automatic logic [31:0] exp_word(input logic [AW-1:0] a);
        int w;
        w = int'(a) / 4;
        if (a[1:0] != 2'b00) return 32'hC0DE_0000;
        case (w)
            0: return 32'hC002_2D15;
            1: return 32'h8001_102C;
            2: return 32'h8001_503A;
            3: return D0;
            4: return D1;
            5: return D2;
            6: return D3;
            7: return 32'h0;
            default: return 32'hC0DE_0000;
        endcase
    endfunction

    function automatic bit exp_break(input logic [AW-1:0] a, input logic [31:0] d);
        return (a == 10'h000 || a == 10'h010) && d == 32'hC0DE_0000;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1; wr_en = 1'b0;
        #1;
        check(tag, rd_data, exp_word(a));
        check("R9 ready on read", {31'b0, ready}, 32'd1);
        @(negedge clk);
        rd_en = 1'b0;
        #1;
        check("R10 idle rd_data", rd_data, 32'h0);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        bit e;
        e = exp_break(a, d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
        #1;
        check("R9 ready on write", {31'b0, ready}, 32'd1);
        check({tag, " no pulse in write cycle"}, {31'b0, bus_rst}, 32'd0);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check(tag, {31'b0, bus_rst}, {31'b0, e});
        check("R9 ready idle", {31'b0, ready}, 32'd0);
        @(negedge clk);
        #1;
        check({tag, " pulse one cycle"}, {31'b0, bus_rst}, 32'd0);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        check("R11 reset bus_rst low", {31'b0, bus_rst}, 32'd0);
        check("R9 reset ready low", {31'b0, ready}, 32'd0);
        check("R10 reset rd_data zero", rd_data, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        do_read(10'h000, "R1 chip id");
        do_read(10'h004, "R2 peek descriptor");
        do_read(10'h008, "R3 bus descriptor");
        for (int k = 0; k < NENG; k++) do_read(AW'(12 + 4 * k), "R4 attached descriptor");
        do_read(10'h01C, "R5 end word");
        do_read(10'h020, "R6 first error word");
        do_read(10'h3FC, "R6 last word of window");
        do_read(10'h002, "R12 misaligned read");

        do_write(10'h000, 32'hC0DE_0000, "R7 break at 0x000");
        do_write(10'h010, 32'hC0DE_0000, "R7 break at 0x010");
        do_write(10'h000, 32'hC0DE_0001, "R8 wrong value at 0x000");
        do_write(10'h008, 32'hC0DE_0000, "R8 break at 0x008");
        do_write(10'h014, 32'hC0DE_0000, "R8 break at 0x014");
        do_write(10'h001, 32'hC0DE_0000, "R12 misaligned break");
        do_read(10'h000, "R8 id after writes");
        do_read(10'h004, "R8 peek after writes");

        // Back-to-back break writes: one pulse per write
        @(negedge clk);
        addr = 10'h000; wr_data = 32'hC0DE_0000; wr_en = 1'b1;
        @(negedge clk);
        addr = 10'h010;
        #1;
        check("R7 first of pair", {31'b0, bus_rst}, 32'd1);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R7 second of pair", {31'b0, bus_rst}, 32'd1);
        @(negedge clk);
        #1;
        check("R7 pair ends", {31'b0, bus_rst}, 32'd0);

        // Reset during a break write cancels the pulse
        @(negedge clk);
        addr = 10'h000; wr_data = 32'hC0DE_0000; wr_en = 1'b1; rst = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R11 pulse suppressed by reset", {31'b0, bus_rst}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        do_read(10'h000, "R11 id after reset");
        do_read(10'h010, "R11 descriptor after reset");

        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] a;
            logic [31:0]   d;
            int            sel;
            sel = int'($urandom % 8);
            a   = AW'($urandom % 1024);
            if (sel < 5) begin
                if (sel < 4) a[1:0] = 2'b00;
                if (sel == 0) a = AW'(($urandom % 10) * 4);
                do_read(a, "R4 R5 R6 random read");
            end else begin
                d = $urandom;
                if (sel == 7) d = 32'hC0DE_0000;
                if (sel == 6) a = ($urandom % 2 == 0) ? 10'h000 : 10'h010;
                do_write(a, d, "R7 R8 random write");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

endmodule